// File: doc/BRIEF.md
# Compare-and-Jump Condition Unit

This block decides, once per clock, where the next instruction fetch goes. It receives the current 32-bit instruction word, the two source operand values already read from the register file, the current instruction pointer, the dedicated jump-target register, and an interrupt request with its enable and vector address. When the instruction is a compare-and-jump, the unit evaluates the 4-bit condition carried in the instruction against the operands. It then registers a taken flag, an invalid-condition flag, an interrupt-taken flag and the next fetch address.

Two jump encodings are recognised by opcode. The register form compares the first source value with the second. The immediate form compares the first source value with a 16-bit constant taken from the low half of the instruction. A jump never carries its own target. A taken jump always goes to the jump-target register. An enabled interrupt overrides both the jump and the sequential step.

Top module: `jump_cond_unit`

## Requirements
- R1: Bits [31:24] are the opcode and bits [23:20] are the condition code. Only opcode JR_OPCODE (default 0x40) and opcode JI_OPCODE (default 0x41) are evaluated. Any other opcode yields jump_taken=0 and cond_invalid=0.
- R2: With opcode JR_OPCODE, operand A is rs1_val and operand B is rs2_val.
- R3: With opcode JI_OPCODE, operand B is bits [15:0] of the instruction. It is sign-extended for conditions 0xC and 0xD and zero-extended for all other conditions.
- R4: Condition 0x0 always jumps. Condition 0x1 jumps when A != B. Condition 0x2 jumps when A == B.
- R5: Condition 0x3 jumps when A > B unsigned. Condition 0x4 jumps when A >= B unsigned.
- R6: Condition 0xC jumps when A > B signed. Condition 0xD jumps when A >= B signed.
- R7: On a jump opcode, any condition other than 0x0, 0x1, 0x2, 0x3, 0x4, 0xC and 0xD gives jump_taken=0 and cond_invalid=1.
- R8: When the jump is taken and no interrupt is taken, next_addr equals ja_val.
- R9: When neither a jump nor an interrupt is taken, next_addr equals ip_val + 1.
- R10: When irq_req and irq_en are both high, irq_taken=1 and next_addr equals irq_vec, whatever the jump outcome. jump_taken still reports the condition result.
- R11: When irq_en is low, irq_req has no effect on irq_taken or next_addr.
- R12: All outputs are registered with one cycle of latency. While rst_n is low at a clock edge, the outputs become next_addr=RESET_ADDR (default 0) and all flags 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr | input | 32 | Current instruction word |
| rs1_val | input | 32 | First source operand value |
| rs2_val | input | 32 | Second source operand value |
| ip_val | input | 32 | Current instruction pointer |
| ja_val | input | 32 | Jump-target register value |
| irq_req | input | 1 | Interrupt request |
| irq_en | input | 1 | Interrupt enable |
| irq_vec | input | 32 | Interrupt handler address |
| jump_taken | output | 1 | Jump condition met (registered) |
| cond_invalid | output | 1 | Jump opcode with unknown condition (registered) |
| irq_taken | output | 1 | Interrupt redirect chosen (registered) |
| next_addr | output | 32 | Next fetch address (registered) |

## Verification
The bound checker watches the address selection on every cycle. It checks that interrupt redirection wins and goes to the previous cycle's vector, that a masked request never redirects, and that a taken jump lands on the previous jump-target value. It also checks that every other cycle steps the pointer by one, that an invalid condition never jumps, and that non-jump opcodes raise no flag. Whether each condition code compares the correct operands with the correct signedness, including the immediate extension rule, is shown only by the bench. The bench does this with random and boundary operand pairs checked against its own model.

// File: rtl/jcu_pkg.sv
// Package: shared field positions and condition-code values for the
// compare-and-jump condition unit. Assumes 32-bit instruction words.
package jcu_pkg;
    localparam int INSTR_W  = 32;
    localparam int OPC_MSB  = 31;
    localparam int OPC_LSB  = 24;
    localparam int COND_MSB = 23;
    localparam int COND_LSB = 20;
    localparam int IMM_W    = 16;

    typedef enum logic [3:0] {
        CC_ALWAYS = 4'h0,
        CC_NE     = 4'h1,
        CC_EQ     = 4'h2,
        CC_UGT    = 4'h3,
        CC_UGE    = 4'h4,
        CC_SGT    = 4'hC,
        CC_SGE    = 4'hD
    } cond_e;
endpackage

// File: rtl/jcu_operand_sel.sv
// Module: selects the second compare operand. In immediate form it takes
// the low IMM_W bits of the instruction. It sign-extends them when the
// condition is signed and zero-extends them otherwise.
// Assumes XLEN >= IMM_W.
module jcu_operand_sel #(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16
) (
    input  logic            use_imm,
    input  logic            signed_cmp,
    input  logic [XLEN-1:0] reg_b,
    input  logic [IMM_W-1:0] imm,
    output logic [XLEN-1:0] opnd_b
);
    localparam int EXT_W = XLEN - IMM_W;

    logic [XLEN-1:0] imm_ext;

    generate
        if (EXT_W > 0) begin : g_ext
            // Extend the immediate to the datapath width.
            always_comb imm_ext = {{EXT_W{signed_cmp & imm[IMM_W-1]}}, imm};
        end else begin : g_noext
            // The immediate already fills the datapath.
            always_comb imm_ext = imm[XLEN-1:0];
        end
    endgenerate

    // Pick the register or the extended immediate.
    always_comb opnd_b = use_imm ? imm_ext : reg_b;
endmodule

// File: rtl/jcu_cond_eval.sv
// Module: evaluates one 4-bit condition code against two operands.
// Codes that are not defined report bad=1 and never hit.
module jcu_cond_eval #(
    parameter int XLEN = 32
) (
    input  logic [3:0]      cond,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic            hit,
    output logic            bad
);
    import jcu_pkg::*;

    logic eq, ugt, sgt;

    // Basic relations shared by every condition.
    always_comb begin
        eq  = (a == b);
        ugt = (a > b);
        sgt = ($signed(a) > $signed(b));
    end

    // Map the condition code onto one relation.
    always_comb begin
        hit = 1'b0;
        bad = 1'b0;
        case (cond)
            CC_ALWAYS: hit = 1'b1;
            CC_NE:     hit = ~eq;
            CC_EQ:     hit = eq;
            CC_UGT:    hit = ugt;
            CC_UGE:    hit = ugt | eq;
            CC_SGT:    hit = sgt;
            CC_SGE:    hit = sgt | eq;
            default:   bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/jcu_next_sel.sv
// Module: next fetch address priority. An interrupt comes first, then a
// taken jump, then the pointer plus one word.
module jcu_next_sel #(
    parameter int XLEN = 32
) (
    input  logic            irq_fire,
    input  logic            jmp_fire,
    input  logic [XLEN-1:0] vec,
    input  logic [XLEN-1:0] ja,
    input  logic [XLEN-1:0] ip,
    output logic [XLEN-1:0] nxt
);
    localparam logic [XLEN-1:0] ONE = {{(XLEN-1){1'b0}}, 1'b1};

    // Priority mux for the next address.
    always_comb begin
        if (irq_fire)      nxt = vec;
        else if (jmp_fire) nxt = ja;
        else               nxt = ip + ONE;
    end
endmodule

// File: rtl/jump_cond_unit.sv
// Module: top of the compare-and-jump condition unit. It decodes the jump
// opcodes, evaluates the condition and registers the flags and the next
// fetch address. Assumes the operands are already read from the register
// file and are valid in the same cycle as the instruction.
module jump_cond_unit #(
    parameter int               XLEN      = 32,
    parameter logic [7:0]       JR_OPCODE = 8'h40,
    parameter logic [7:0]       JI_OPCODE = 8'h41,
    parameter logic [XLEN-1:0]  RESET_ADDR = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] rs1_val,
    input  logic [XLEN-1:0] rs2_val,
    input  logic [XLEN-1:0] ip_val,
    input  logic [XLEN-1:0] ja_val,
    input  logic            irq_req,
    input  logic            irq_en,
    input  logic [XLEN-1:0] irq_vec,
    output logic            jump_taken,
    output logic            cond_invalid,
    output logic            irq_taken,
    output logic [XLEN-1:0] next_addr
);
    import jcu_pkg::*;

    logic [7:0]       opc;
    logic [3:0]       cond;
    logic             is_jr, is_ji, is_jump, signed_cmp;
    logic [XLEN-1:0]  opnd_b, nxt;
    logic             hit, bad, jmp_fire, irq_fire;

    // Split the instruction into fields and classify the opcode.
    always_comb begin
        opc        = instr[OPC_MSB:OPC_LSB];
        cond       = instr[COND_MSB:COND_LSB];
        is_jr      = (opc == JR_OPCODE);
        is_ji      = (opc == JI_OPCODE);
        is_jump    = is_jr | is_ji;
        signed_cmp = (cond == CC_SGT) || (cond == CC_SGE);
    end

    jcu_operand_sel #(.XLEN(XLEN), .IMM_W(IMM_W)) u_opsel (
        .use_imm    (is_ji),
        .signed_cmp (signed_cmp),
        .reg_b      (rs2_val),
        .imm        (instr[IMM_W-1:0]),
        .opnd_b     (opnd_b)
    );

    jcu_cond_eval #(.XLEN(XLEN)) u_eval (
        .cond (cond),
        .a    (rs1_val),
        .b    (opnd_b),
        .hit  (hit),
        .bad  (bad)
    );

    // Qualify the condition result and the interrupt request.
    always_comb begin
        jmp_fire = is_jump & hit;
        irq_fire = irq_req & irq_en;
    end

    jcu_next_sel #(.XLEN(XLEN)) u_next (
        .irq_fire (irq_fire),
        .jmp_fire (jmp_fire),
        .vec      (irq_vec),
        .ja       (ja_val),
        .ip       (ip_val),
        .nxt      (nxt)
    );

    // Output registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            jump_taken   <= 1'b0;
            cond_invalid <= 1'b0;
            irq_taken    <= 1'b0;
            next_addr    <= RESET_ADDR;
        end else begin
            jump_taken   <= jmp_fire;
            cond_invalid <= is_jump & bad;
            irq_taken    <= irq_fire;
            next_addr    <= nxt;
        end
    end
endmodule

// File: rtl/jcu_checker.sv
// Checker: cycle-by-cycle properties of the condition unit's outputs
// against the inputs of the previous cycle. Bound to jump_cond_unit.
module jcu_checker #(
    parameter int         XLEN      = 32,
    parameter logic [7:0] JR_OPCODE = 8'h40,
    parameter logic [7:0] JI_OPCODE = 8'h41
) (
    input logic            clk,
    input logic            rst_n,
    input logic [31:0]     instr,
    input logic [XLEN-1:0] ip_val,
    input logic [XLEN-1:0] ja_val,
    input logic            irq_req,
    input logic            irq_en,
    input logic [XLEN-1:0] irq_vec,
    input logic            jump_taken,
    input logic            cond_invalid,
    input logic            irq_taken,
    input logic [XLEN-1:0] next_addr
);
    logic armed;

    // armed is high when the previous edge was outside reset.
    always_ff @(posedge clk) armed <= rst_n;

    a_r7_invalid_no_jump: assert property (@(posedge clk) disable iff (!rst_n)
        cond_invalid |-> !jump_taken);

    a_r10_irq_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(irq_req && irq_en)) |-> (irq_taken && next_addr == $past(irq_vec)));

    a_r11_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !$past(irq_en)) |-> !irq_taken);

    a_r8_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && jump_taken && !irq_taken) |-> next_addr == $past(ja_val));

    a_r9_sequential: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !jump_taken && !irq_taken) |-> next_addr == $past(ip_val) + 1);

    a_r1_other_opcode: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(instr[31:24] != JR_OPCODE && instr[31:24] != JI_OPCODE))
        |-> (!jump_taken && !cond_invalid));
endmodule

bind jump_cond_unit jcu_checker #(
    .XLEN(XLEN), .JR_OPCODE(JR_OPCODE), .JI_OPCODE(JI_OPCODE)
) u_jcu_checker (
    .clk(clk), .rst_n(rst_n), .instr(instr), .ip_val(ip_val), .ja_val(ja_val),
    .irq_req(irq_req), .irq_en(irq_en), .irq_vec(irq_vec),
    .jump_taken(jump_taken), .cond_invalid(cond_invalid),
    .irq_taken(irq_taken), .next_addr(next_addr)
);

// File: tb/jump_cond_unit_tb_top.sv
// Bench: directed corner cases plus seeded random stimulus, compared with
// a model written from the requirements.
module jump_cond_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] OP_JR = 8'h40;
    localparam logic [7:0] OP_JI = 8'h41;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] instr, rs1_val, rs2_val, ip_val, ja_val, irq_vec;
    logic        irq_req, irq_en;
    logic        jump_taken, cond_invalid, irq_taken;
    logic [31:0] next_addr;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    jump_cond_unit dut_i (
        .clk(clk), .rst_n(rst_n), .instr(instr), .rs1_val(rs1_val),
        .rs2_val(rs2_val), .ip_val(ip_val), .ja_val(ja_val),
        .irq_req(irq_req), .irq_en(irq_en), .irq_vec(irq_vec),
        .jump_taken(jump_taken), .cond_invalid(cond_invalid),
        .irq_taken(irq_taken), .next_addr(next_addr)
    );

    // Model of the condition outcome: bit1 = jump, bit0 = invalid.
    function automatic logic [1:0] model_cond(input logic [31:0] ins,
                                              input logic [31:0] a,
                                              input logic [31:0] rb);
        logic [7:0]  op = ins[31:24];
        logic [3:0]  c  = ins[23:20];
        logic [31:0] b;
        logic        sgn = (c == 4'hC) || (c == 4'hD);
        if (op != OP_JR && op != OP_JI) return 2'b00;
        if (op == OP_JI) b = sgn ? {{16{ins[15]}}, ins[15:0]} : {16'h0, ins[15:0]};
        else b = rb;
        case (c)
            4'h0: return 2'b10;
            4'h1: return {a != b, 1'b0};
            4'h2: return {a == b, 1'b0};
            4'h3: return {a > b, 1'b0};
            4'h4: return {a >= b, 1'b0};
            4'hC: return {$signed(a) > $signed(b), 1'b0};
            4'hD: return {$signed(a) >= $signed(b), 1'b0};
            default: return 2'b01;
        endcase
    endfunction

    // Requirement tag for a given instruction.
    function automatic string tag_of(input logic [31:0] ins);
        logic [3:0] c = ins[23:20];
        if (ins[31:24] != OP_JR && ins[31:24] != OP_JI) return "R1";
        case (c)
            4'h0, 4'h1, 4'h2: return (ins[31:24] == OP_JI) ? "R3/R4" : "R2/R4";
            4'h3, 4'h4:       return (ins[31:24] == OP_JI) ? "R3/R5" : "R2/R5";
            4'hC, 4'hD:       return (ins[31:24] == OP_JI) ? "R3/R6" : "R2/R6";
            default:          return "R7";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Apply one set of inputs, clock once, check all outputs.
    task automatic apply(input logic [31:0] ins, input logic [31:0] a,
                         input logic [31:0] b, input logic ireq, input logic ien);
        logic [1:0]  r;
        logic [31:0] exp_addr;
        string       t;
        logic        irq_go;
        @(negedge clk);
        instr = ins; rs1_val = a; rs2_val = b;
        ip_val = $urandom; ja_val = $urandom; irq_vec = $urandom;
        irq_req = ireq; irq_en = ien;
        r = model_cond(ins, a, b);
        t = tag_of(ins);
        irq_go = ireq & ien;
        exp_addr = irq_go ? irq_vec : (r[1] ? ja_val : ip_val + 32'd1);
        @(posedge clk); #1;
        check(t, "jump_taken", {31'b0, jump_taken}, {31'b0, r[1]});
        check(t, "cond_invalid", {31'b0, cond_invalid}, {31'b0, r[0]});
        check(irq_go ? "R10" : (ireq ? "R11" : "R12"), "irq_taken",
              {31'b0, irq_taken}, {31'b0, irq_go});
        check(irq_go ? "R10" : (r[1] ? "R8" : "R9"), "next_addr", next_addr, exp_addr);
    endtask

    function automatic logic [31:0] mk(input logic [7:0] op, input logic [3:0] c,
                                       input logic [15:0] imm);
        return {op, c, 4'h1, imm};
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd1234));
        rst_n = 1'b0; instr = '0; rs1_val = '0; rs2_val = '0; ip_val = 32'h55;
        ja_val = 32'h77; irq_req = 1'b1; irq_en = 1'b1; irq_vec = 32'h99;
        repeat (2) @(posedge clk); #1;
        check("R12", "reset next_addr", next_addr, 32'h0);
        check("R12", "reset flags", {29'b0, jump_taken, cond_invalid, irq_taken}, 32'h0);
        rst_n = 1'b1;

        // Directed corners.
        apply(mk(OP_JR, 4'h0, 16'h0), 32'h5, 32'h6, 0, 0);              // R4 always
        apply(mk(OP_JR, 4'h2, 16'h0), 32'hDEAD, 32'hDEAD, 0, 0);        // R4 equal
        apply(mk(OP_JR, 4'h1, 16'h0), 32'hDEAD, 32'hDEAD, 0, 0);        // R4 ne false
        apply(mk(OP_JR, 4'h3, 16'h0), 32'hFFFF_FFFF, 32'h1, 0, 0);      // R5 ugt
        apply(mk(OP_JR, 4'hC, 16'h0), 32'hFFFF_FFFF, 32'h1, 0, 0);      // R6 sgt false
        apply(mk(OP_JR, 4'h4, 16'h0), 32'h7, 32'h7, 0, 0);              // R5 uge equal
        apply(mk(OP_JR, 4'hD, 16'h0), 32'h8000_0000, 32'h8000_0000, 0, 0); // R6 sge equal
        apply(mk(OP_JI, 4'hC, 16'hFFFF), 32'h0, 32'h0, 0, 0);           // R3 sign ext: 0 > -1
        apply(mk(OP_JI, 4'h3, 16'hFFFF), 32'h0001_0000, 32'h0, 0, 0);   // R3 zero ext
        apply(mk(OP_JI, 4'h2, 16'h8000), 32'h0000_8000, 32'h0, 0, 0);   // R3 zero ext eq
        apply(mk(OP_JI, 4'h2, 16'h8000), 32'hFFFF_8000, 32'h0, 0, 0);   // R3 eq false
        apply(mk(OP_JR, 4'h7, 16'h0), 32'h1, 32'h1, 0, 0);              // R7 invalid
        apply(mk(OP_JR, 4'hF, 16'h0), 32'h1, 32'h1, 0, 0);              // R7 invalid
        apply(mk(8'h00, 4'h7, 16'h0), 32'h1, 32'h1, 0, 0);              // R1 other opcode
        apply(mk(OP_JR, 4'h0, 16'h0), 32'h1, 32'h1, 1, 1);              // R10 irq over jump
        apply(mk(OP_JR, 4'h0, 16'h0), 32'h1, 32'h1, 1, 0);              // R11 masked
        apply(mk(8'h12, 4'h0, 16'h0), 32'h1, 32'h1, 1, 0);              // R11 masked, R9

        // Seeded random stimulus.
        for (int i = 0; i < 600; i++) begin
            logic [31:0] rn = $urandom;
            logic [7:0]  op = (rn[1:0] == 2'd0) ? 8'(rn[15:8]) : (rn[2] ? OP_JI : OP_JR);
            logic [31:0] a  = $urandom;
            logic [31:0] b  = rn[5:4] == 2'd0 ? a : $urandom;
            logic [15:0] im = rn[7:6] == 2'd0 ? a[15:0] : 16'($urandom);
            if (rn[9:8] == 2'd0) a = {{16{im[15]}}, im};
            apply({op, 4'($urandom), 4'h3, im}, a, b, rn[10], rn[11]);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule